// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Controller

This block is a clocked model of the control logic of a DRAM array. It samples the active-low row strobe, column strobe and write-enable on a system clock, and it records each row-strobe falling edge. From the strobe levels around that edge it sorts every row cycle into one of four kinds: an ordinary access, a refresh where only the row strobe moves, a column-before-row refresh, and a column-before-row refresh with write-enable held low.

That last ordering switches on a latched compressed-test mode. Either of the two plain refresh kinds switches it off again. While the mode is active, each read looks at all eight internal bits behind every data pin. The pin reports high if the eight bits agree and low if they do not. The mode adds one clock of read latency. A power-up sequencer keeps the block not-ready, and read data off the pins, until a start-up wait and eight refresh cycles have completed.

Top module: `dram_ptest_ctrl`

## Requirements
- R1: A synchronous active-high reset clears test mode, clears ready and clears the output enable, and restarts the power-up sequence.
- R2: `ready` rises only after WAIT_CYC clocks from reset and then eight counted refresh cycles. Refresh cycles seen during the wait are not counted. It rises two clocks after the sample that completes the eighth refresh, and it stays high until reset.
- R3: A column-before-row refresh counts toward initialization. This is a row-strobe fall sampled with the column strobe low and write-enable high. A row-strobe-only refresh also counts: the row strobe is low for a whole period with the column strobe high throughout. A fall with both the column strobe and write-enable low does not count.
- R4: When `ready` is high, a row-strobe fall sampled with both the column strobe and write-enable low sets `test_mode`. Before `ready`, that ordering leaves `test_mode` at 0.
- R5: `test_mode` stays set through access cycles, meaning a row-strobe fall with the column strobe high that is followed by a column-strobe fall.
- R6: While `ready` is high, a row-strobe-only refresh or a column-before-row refresh with write-enable high clears `test_mode`.
- R7: A normal read happens when the column strobe is sampled low in an open access row with write-enable high. It drives `dq_out[i] = rd_data[8*i + s]` with `dq_oe` high, where s = {col_addr[10], col_addr[1], col_addr[0]}, on the clock after that sample.
- R8: In test mode, a read drives `dq_out[i]` to 1 if all eight bits `rd_data[8*i +: 8]` are equal and to 0 otherwise. The result appears two clocks after the sample, and `dq_oe` is low on the first clock.
- R9: In test mode, col_addr bits 10, 1 and 0 have no effect on the data driven.
- R10: `dq_oe` is low after any clock that samples the column strobe high, even when a delayed test-mode result is pending. It is also low for write cycles (write-enable low) and before `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_addr | input | COL_W | Column address |
| rd_data | input | DQ_W*COMP | Internal read bits, COMP per data pin |
| dq_out | output | DQ_W | Data pin levels |
| dq_oe | output | 1 | Data pin output enable |
| test_mode | output | 1 | Compressed test mode active |
| ready | output | 1 | Power-up sequence complete |

## Verification
The delayed test-mode result and the output disable on a column-strobe rise can fall in the same clock. If the column strobe is raised right after the last test-mode read, the result of that read is still in flight when the strobe goes high. The bench provokes this by raising the strobe straight after a test read, and it expects `dq_oe` low in the clock where that result would otherwise appear. A second overlap is a refresh that lands during the power-up wait or just before `ready`. The bench judges it through the exact clock in which `ready` rises and through `test_mode` staying at 0.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {
    CYC_NONE     = 2'd0,
    CYC_WCBR     = 2'd1,
    CYC_CBR      = 2'd2,
    CYC_RAS_ONLY = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/ptc_strobe_decode.sv
module ptc_strobe_decode
  import ptc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cyc_kind_e kind,
  output logic      rd_cand
);
  logic ras_d;
  logic row_open;
  logic cas_seen;
  logic ras_fall;
  logic ras_rise;

  assign ras_fall = ras_d & ~ras_n;
  assign ras_rise = ~ras_d & ras_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_d    <= 1'b1;
      row_open <= 1'b0;
      cas_seen <= 1'b0;
    end else begin
      ras_d <= ras_n;
      if (ras_fall) begin
        row_open <= cas_n;
        cas_seen <= 1'b0;
      end else if (ras_rise) begin
        row_open <= 1'b0;
        cas_seen <= 1'b0;
      end else if (row_open && !cas_n) begin
        cas_seen <= 1'b1;
      end
    end
  end

  always_comb begin
    kind = CYC_NONE;
    if (ras_fall && !cas_n) begin
      kind = we_n ? CYC_CBR : CYC_WCBR;
    end else if (ras_rise && row_open && !cas_seen && cas_n) begin
      kind = CYC_RAS_ONLY;
    end
  end

  assign rd_cand = row_open & ~ras_n & ~cas_n & we_n;

  AST_RAS_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_RAS_ONLY) |-> ($past(!ras_n) && $past(cas_n))); // R3
endmodule

// File: rtl/ptc_init_seq.sv
module ptc_init_seq #(
  parameter int WAIT_CYC = 40000,
  parameter int INIT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic init_ev,
  output logic ready
);
  localparam int WAIT_W = $clog2(WAIT_CYC + 1);
  localparam int INIT_W = $clog2(INIT_CYC + 1);

  logic [WAIT_W-1:0] wait_cnt;
  logic [INIT_W-1:0] init_cnt;
  logic              wait_done;
  logic              init_done;

  assign wait_done = (wait_cnt == WAIT_W'(WAIT_CYC));
  assign init_done = (init_cnt == INIT_W'(INIT_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
      init_cnt <= '0;
      ready    <= 1'b0;
    end else begin
      if (!wait_done) wait_cnt <= wait_cnt + 1'b1;
      if (wait_done && init_ev && !init_done) init_cnt <= init_cnt + 1'b1;
      ready <= wait_done && init_done;
    end
  end

  AST_INIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    init_cnt <= INIT_W'(INIT_CYC)); // R2
endmodule

// File: rtl/ptc_read_path.sv
module ptc_read_path #(
  parameter int DQ_W  = 4,
  parameter int COMP  = 8,
  parameter int COL_W = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_req,
  input  logic                 test_mode,
  input  logic                 cas_n,
  input  logic [COL_W-1:0]     col_addr,
  input  logic [DQ_W*COMP-1:0] rd_data,
  output logic [DQ_W-1:0]      dq_out,
  output logic                 dq_oe
);
  localparam int SEL_W = $clog2(COMP);

  logic [SEL_W-1:0] sel;
  logic [DQ_W-1:0]  nrm;
  logic [DQ_W-1:0]  cmp;
  logic [DQ_W-1:0]  pend_d;
  logic             pend_v;
  logic             col_unused;

  assign sel        = {col_addr[COL_W-1], col_addr[SEL_W-2:0]};
  assign col_unused = ^col_addr[COL_W-2:SEL_W-1];

  for (genvar i = 0; i < DQ_W; i++) begin : g_pin
    logic [COMP-1:0] grp;
    assign grp    = rd_data[i*COMP +: COMP];
    assign nrm[i] = grp[sel];
    assign cmp[i] = (&grp) | ~(|grp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_d <= '0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      pend_v <= rd_req & test_mode;
      pend_d <= cmp;
      if (!cas_n && pend_v) begin
        dq_oe  <= 1'b1;
        dq_out <= pend_d;
      end else if (!cas_n && rd_req && !test_mode) begin
        dq_oe  <= 1'b1;
        dq_out <= nrm;
      end else begin
        dq_oe  <= 1'b0;
        dq_out <= '0;
      end
    end
  end

  AST_OE_CAS: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !$past(cas_n)); // R10
endmodule

// File: rtl/dram_ptest_ctrl.sv
module dram_ptest_ctrl
  import ptc_pkg::*;
#(
  parameter int DQ_W     = 4,
  parameter int COMP     = 8,
  parameter int COL_W    = 11,
  parameter int WAIT_CYC = 40000,
  parameter int INIT_CYC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [COL_W-1:0]     col_addr,
  input  logic [DQ_W*COMP-1:0] rd_data,
  output logic [DQ_W-1:0]      dq_out,
  output logic                 dq_oe,
  output logic                 test_mode,
  output logic                 ready
);
  cyc_kind_e kind;
  logic      rd_cand;
  logic      rd_req;
  logic      init_ev;
  logic      ready_q;
  logic      tm_q;

  ptc_strobe_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .kind    (kind),
    .rd_cand (rd_cand)
  );

  assign init_ev = (kind == CYC_CBR) || (kind == CYC_RAS_ONLY);

  ptc_init_seq #(.WAIT_CYC(WAIT_CYC), .INIT_CYC(INIT_CYC)) u_init (
    .clk     (clk),
    .rst     (rst),
    .init_ev (init_ev),
    .ready   (ready_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tm_q <= 1'b0;
    end else if (ready_q) begin
      case (kind)
        CYC_WCBR:              tm_q <= 1'b1;
        CYC_CBR, CYC_RAS_ONLY: tm_q <= 1'b0;
        default:               tm_q <= tm_q;
      endcase
    end
  end

  assign rd_req = rd_cand & ready_q;

  ptc_read_path #(.DQ_W(DQ_W), .COMP(COMP), .COL_W(COL_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .test_mode (tm_q),
    .cas_n     (cas_n),
    .col_addr  (col_addr),
    .rd_data   (rd_data),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  assign test_mode = tm_q;
  assign ready     = ready_q;

  AST_TM_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(tm_q) |-> ready_q); // R4
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> ready_q); // R2
endmodule

// File: tb/dram_ptest_ctrl_tb.sv
`timescale 1ns/1ps
module dram_ptest_ctrl_tb;
  localparam int DQ_W = 4, COMP = 8, COL_W = 11, WAITC = 20, INITC = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [COL_W-1:0] col_addr = '0;
  logic [DQ_W*COMP-1:0] rd_data = '0;
  logic [DQ_W-1:0] dq_out;
  logic dq_oe, test_mode, ready;

  dram_ptest_ctrl #(.DQ_W(DQ_W), .COMP(COMP), .COL_W(COL_W),
                    .WAIT_CYC(WAITC), .INIT_CYC(INITC)) u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .col_addr(col_addr), .rd_data(rd_data), .dq_out(dq_out),
    .dq_oe(dq_oe), .test_mode(test_mode), .ready(ready));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int at; int kind; logic [3:0] exp; string req;} item_t;
  item_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic expect_at(input int at, input int kind, input logic [3:0] e, input string req);
    item_t it;
    it.at = at; it.kind = kind; it.exp = e; it.req = req;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at == cyc) begin
        n_cmp++;
        case (sbq[i].kind)
          0: if (!(dq_oe === 1'b1 && dq_out === sbq[i].exp)) begin
               n_bad++;
               $display("FAIL %s cyc %0d: dq_oe=%b dq_out=%b, expected dq_oe=1 dq_out=%b",
                        sbq[i].req, cyc, dq_oe, dq_out, sbq[i].exp);
             end
          1: if (dq_oe !== 1'b0) begin
               n_bad++;
               $display("FAIL %s cyc %0d: dq_oe=%b, expected 0", sbq[i].req, cyc, dq_oe);
             end
          2: if (test_mode !== sbq[i].exp[0]) begin
               n_bad++;
               $display("FAIL %s cyc %0d: test_mode=%b, expected %b",
                        sbq[i].req, cyc, test_mode, sbq[i].exp[0]);
             end
          default: if (ready !== sbq[i].exp[0]) begin
               n_bad++;
               $display("FAIL %s cyc %0d: ready=%b, expected %b",
                        sbq[i].req, cyc, ready, sbq[i].exp[0]);
             end
        endcase
        sbq.delete(i);
      end
    end
  end

  function automatic logic [3:0] f_norm(input logic [31:0] d, input logic [10:0] a);
    logic [3:0] r;
    logic [2:0] s;
    s = {a[10], a[1], a[0]};
    for (int i = 0; i < 4; i++) r[i] = d[i*8 + s];
    return r;
  endfunction

  function automatic logic [3:0] f_cmp(input logic [31:0] d);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (d[i*8 +: 8] == 8'h00) || (d[i*8 +: 8] == 8'hFF);
    return r;
  endfunction

  task automatic drv(input logic r, input logic c, input logic w,
                     input logic [10:0] a, input logic [31:0] d, output int n);
    @(posedge clk); #1;
    ras_n = r; cas_n = c; we_n = w; col_addr = a; rd_data = d;
    n = cyc;
  endtask

  task automatic idle(input int k);
    int n;
    for (int i = 0; i < k; i++) drv(1, 1, 1, '0, '0, n);
  endtask

  task automatic cbr(input logic w, output int n);
    drv(1, 0, w, '0, '0, n);
    drv(0, 0, w, '0, '0, n);
    drv(0, 0, 1, '0, '0, n);
    drv(1, 1, 1, '0, '0, n);
  endtask

  task automatic ras_only(output int n);
    drv(1, 1, 1, '0, '0, n);
    drv(0, 1, 1, '0, '0, n);
    drv(0, 1, 1, '0, '0, n);
    drv(1, 1, 1, '0, '0, n);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] d;
    // reset state (R1)
    drv(1, 1, 1, '0, '0, n);
    drv(1, 1, 1, '0, '0, n);
    @(posedge clk); #1; rst = 0; n = cyc;
    expect_at(n, 2, 4'h0, "R1");
    expect_at(n, 3, 4'h0, "R1");
    expect_at(n, 1, 4'h0, "R1");
    // refresh during wait: not counted (R2)
    cbr(1, n);
    // read attempt before ready: no output (R10)
    drv(1, 1, 1, '0, '0, n);
    drv(0, 1, 1, '0, '0, n);
    drv(0, 0, 1, 11'h000, 32'hFFFF_FFFF, n);
    expect_at(n + 1, 1, 4'h0, "R10");
    drv(0, 1, 1, '0, '0, n);
    drv(1, 1, 1, '0, '0, n);
    idle(WAITC);
    // seven counted refreshes plus a WCBR that neither counts nor enters test (R3, R4)
    for (int i = 0; i < 7; i++) cbr(1, n);
    cbr(0, n);
    expect_at(n + 1, 2, 4'h0, "R4");
    idle(3);
    drv(1, 1, 1, '0, '0, n);
    expect_at(n + 1, 3, 4'h0, "R3");
    // eighth counted refresh: row-strobe-only (R2, R3)
    ras_only(n);
    expect_at(n + 1, 3, 4'h0, "R2");
    expect_at(n + 2, 3, 4'h1, "R2");
    idle(2);
    // normal reads (R7), write and strobe-high disable (R10)
    drv(1, 1, 1, '0, '0, n);
    drv(0, 1, 1, '0, '0, n);
    expect_at(n + 1, 1, 4'h0, "R10");
    drv(0, 0, 1, 11'h000, 32'hA5C3_0F96, n);
    expect_at(n + 1, 0, f_norm(32'hA5C3_0F96, 11'h000), "R7");
    drv(0, 0, 1, 11'h403, 32'h1234_89EF, n);
    expect_at(n + 1, 0, f_norm(32'h1234_89EF, 11'h403), "R7");
    drv(0, 0, 1, 11'h002, 32'hFFFF_0000, n);
    expect_at(n + 1, 0, f_norm(32'hFFFF_0000, 11'h002), "R7");
    drv(0, 0, 0, 11'h000, 32'hFFFF_FFFF, n);
    expect_at(n + 1, 1, 4'h0, "R10");
    drv(0, 1, 1, '0, '0, n);
    expect_at(n + 1, 1, 4'h0, "R10");
    drv(1, 1, 1, '0, '0, n);
    // enter test mode (R4)
    cbr(0, n);
    expect_at(n + 1, 2, 4'h1, "R4");
    idle(1);
    // test reads (R8, R9), collision with strobe rise (R10), latched across access (R5)
    d = 32'hFF00_A500;
    drv(1, 1, 1, '0, '0, n);
    drv(0, 1, 1, '0, '0, n);
    drv(0, 0, 1, 11'h000, d, n);
    expect_at(n + 1, 1, 4'h0, "R8");
    expect_at(n + 2, 0, f_cmp(d), "R8");
    drv(0, 0, 1, 11'h403, d, n);
    expect_at(n + 2, 0, f_cmp(d), "R9");
    drv(0, 0, 1, 11'h401, 32'h00FF_7E01, n);
    expect_at(n + 2, 1, 4'h0, "R10");
    drv(0, 1, 1, '0, '0, n);
    drv(1, 1, 1, '0, '0, n);
    expect_at(n + 1, 2, 4'h1, "R5");
    idle(1);
    // exit via row-strobe-only refresh (R6)
    ras_only(n);
    expect_at(n + 1, 2, 4'h0, "R6");
    idle(1);
    cbr(0, n);
    expect_at(n + 1, 2, 4'h1, "R4");
    cbr(1, n);
    expect_at(n + 1, 2, 4'h0, "R6");
    idle(1);
    // normal read after exit, one-clock latency (R7)
    drv(1, 1, 1, '0, '0, n);
    drv(0, 1, 1, '0, '0, n);
    drv(0, 0, 1, 11'h000, d, n);
    expect_at(n + 1, 0, f_norm(d, 11'h000), "R7");
    drv(0, 1, 1, '0, '0, n);
    drv(1, 1, 1, '0, '0, n);
    // reset while in test mode (R1)
    cbr(0, n);
    expect_at(n + 1, 2, 4'h1, "R4");
    @(posedge clk); #1; rst = 1; n = cyc;
    expect_at(n + 1, 2, 4'h0, "R1");
    expect_at(n + 1, 3, 4'h0, "R1");
    @(posedge clk); #1; rst = 0;
    idle(4);
    if (sbq.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule